// File: doc/BRIEF.md
# Indirect Configuration-Space Access Bridge

This block connects a host I/O-port bus to the configuration registers of the functions on a peripheral bus. Configuration space is reached through two steps. Software first writes a 32-bit selector word to an address port. That word holds an enable flag and packed bus, device, function and doubleword fields. Software then reads or writes a data port, and the bridge turns that access into one configuration transaction aimed at the doubleword the selector names. Each function has 64 doublewords of configuration space: a 16-doubleword header of fixed format, followed by 48 doublewords of variable content.

Only the address port (default 0x0CF8) and the data port (default 0x0CFC) are claimed, and every access is a full 32 bits. The host holds a strobe until `h_ready` pulses for one cycle. While the selector's enable is clear, the data port reads as all ones and drops writes. If no target acknowledges within a fixed number of cycles, the transaction ends and a read returns all ones, so an absent device reads back as 0xFFFFFFFF.

Control is one state machine with three states. IDLE waits for a claimed strobe. From IDLE there are two transitions. IDLE to RESP (named "local") is taken for any address-port access and for a data-port access while the enable is clear. IDLE to WAIT (named "issue") is taken for a data-port access while the enable is set. WAIT holds the configuration request. WAIT to RESP (named "acked") is taken when the target acknowledges. WAIT to RESP (named "expired") is taken when the timeout runs out with no acknowledge. RESP raises `h_ready` for one cycle, and RESP to IDLE (named "release") is always taken on the next clock.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset, the selector reads back as 0, and `h_ready` and `c_req` are low.
- R2: A write to the address port stores bit 31 (the enable) and bits 23:2. A read of the address port returns the stored word with bits 30:24 and 1:0 as zero. For example, writing 0xFFFFFFFF reads back as 0x80FFFFFC.
- R3: During a request, `c_bus` carries selector bits 23:16, `c_dev` bits 15:11, `c_fn` bits 10:8 and `c_dw` bits 7:2.
- R4: A data-port read with the enable set raises `c_req` with `c_we` = 0. When `c_ack` is seen, `h_ready` pulses on the next cycle and `h_rdata` holds `c_rdata`.
- R5: A data-port write with the enable set raises `c_req` with `c_we` = 1 and `c_wdata` equal to the host write data. The write completes on `c_ack`.
- R6: While the enable is clear, a data-port read completes with 0xFFFFFFFF and a data-port write completes, and neither raises `c_req`.
- R7: If `c_ack` has not come by the TIMEOUT-th cycle of a request, `c_req` drops, the access completes, and a read returns 0xFFFFFFFF. An acknowledge in the TIMEOUT-th cycle still completes normally.
- R8: An access to any other port address keeps `h_claim` low, gets no `h_ready`, raises no request and leaves the selector unchanged. `h_claim` is high exactly when a strobe is active on one of the two ports.
- R9: Only one transaction is outstanding at a time. `h_ready` is a one-cycle pulse, and `c_req` with its fields stays stable until the request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 16 | Host port address |
| h_rd | input | 1 | Host read strobe, held until ready |
| h_wr | input | 1 | Host write strobe, held until ready |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid with h_ready |
| h_ready | output | 1 | One-cycle completion pulse |
| h_claim | output | 1 | Strobe addresses one of the bridge's ports |
| c_req | output | 1 | Configuration request active |
| c_bus | output | 8 | Target bus number |
| c_dev | output | 5 | Target device number |
| c_fn | output | 3 | Target function number |
| c_dw | output | 6 | Target doubleword index |
| c_we | output | 1 | 1 = write, 0 = read |
| c_wdata | output | 32 | Configuration write data |
| c_rdata | input | 32 | Configuration read data, valid with c_ack |
| c_ack | input | 1 | Target acknowledge |

## Verification
The data port is exercised with several selectors, whose bus, device, function and doubleword values differ, and with acknowledge delays of zero, three, TIMEOUT-1 and none at all. Together these tell field-packing errors apart from timing errors, and show exactly where the timeout boundary falls. Writes followed by read-back separate the write path from the read path. Accesses with the enable toggled off, and accesses to neighbouring port addresses, show that neither can issue a request or disturb the stored selector.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RESP = 2'd2
    } cfgb_state_e;

    typedef struct packed {
        logic [7:0] bus;
        logic [4:0] dev;
        logic [2:0] fn;
        logic [5:0] dw;
    } cfg_sel_t;

    localparam int          WORD_W     = 32;
    localparam logic [31:0] SEL_KEEP   = 32'h80FF_FFFC;
    localparam logic [31:0] FLOAT_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] q,
    output logic              en,
    output cfg_sel_t          sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (wr_en)
            q <= wdata & SEL_KEEP;
    end

    assign en      = q[31];
    assign sel.bus = q[23:16];
    assign sel.dev = q[15:11];
    assign sel.fn  = q[10:8];
    assign sel.dw  = q[7:2];

endmodule

// File: rtl/cfgb_timeout.sv
module cfgb_timeout #(
    parameter int TIMEOUT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);

    localparam int CW = $clog2(TIMEOUT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (!hit)
            cnt <= cnt + 1'b1;
    end

    assign hit = run && (cnt == CW'(TIMEOUT - 1));

endmodule

// File: rtl/cfgb_ctrl.sv
module cfgb_ctrl
    import cfgb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              is_addr,
    input  logic              is_wr,
    input  logic              en,
    input  logic [WORD_W-1:0] sel_q,
    input  logic [WORD_W-1:0] h_wdata,
    input  logic              c_ack,
    input  logic [WORD_W-1:0] c_rdata,
    input  logic              tmo_hit,
    output logic              latch_wr,
    output logic              h_ready,
    output logic [WORD_W-1:0] h_rdata,
    output logic              c_req,
    output logic              c_we,
    output logic [WORD_W-1:0] c_wdata
);

    cfgb_state_e st, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st <= ST_IDLE;
        else
            st <= nxt;
    end

    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (acc) begin
                    if (!is_addr && en)
                        nxt = ST_WAIT;   // issue
                    else
                        nxt = ST_RESP;   // local
                end
            end
            ST_WAIT: begin
                if (c_ack || tmo_hit)
                    nxt = ST_RESP;       // acked / expired
            end
            ST_RESP: nxt = ST_IDLE;      // release
            default: nxt = ST_IDLE;
        endcase
    end

    assign h_ready  = (st == ST_RESP);
    assign c_req    = (st == ST_WAIT);
    assign latch_wr = (st == ST_IDLE) && acc && is_addr && is_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_rdata <= '0;
            c_we    <= 1'b0;
            c_wdata <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (acc) begin
                        c_we    <= is_wr;
                        c_wdata <= h_wdata;
                        if (!is_wr) begin
                            if (is_addr)
                                h_rdata <= sel_q;
                            else if (!en)
                                h_rdata <= FLOAT_WORD;
                        end
                    end
                end
                ST_WAIT: begin
                    if (!c_we) begin
                        if (c_ack)
                            h_rdata <= c_rdata;
                        else if (tmo_hit)
                            h_rdata <= FLOAT_WORD;
                    end
                end
                ST_RESP: ;
                default: ;
            endcase
        end
    end

    assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |=> !h_ready);

    assert_no_req_in_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        h_ready |-> !c_req);

endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
    import cfgb_pkg::*;
#(
    parameter int              AW        = 16,
    parameter logic [AW-1:0]   SEL_PORT  = 16'h0CF8,
    parameter logic [AW-1:0]   DATA_PORT = 16'h0CFC,
    parameter int              TIMEOUT   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] h_addr,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [31:0]   h_wdata,
    output logic [31:0]   h_rdata,
    output logic          h_ready,
    output logic          h_claim,
    output logic          c_req,
    output logic [7:0]    c_bus,
    output logic [4:0]    c_dev,
    output logic [2:0]    c_fn,
    output logic [5:0]    c_dw,
    output logic          c_we,
    output logic [31:0]   c_wdata,
    input  logic [31:0]   c_rdata,
    input  logic          c_ack
);

    logic        hit_sel, hit_data, acc, is_wr;
    logic        latch_wr, sel_en, tmo_hit;
    logic [31:0] sel_q;
    cfg_sel_t    sel;

    assign hit_sel  = (h_addr == SEL_PORT);
    assign hit_data = (h_addr == DATA_PORT);
    assign acc      = (h_rd || h_wr) && (hit_sel || hit_data);
    assign is_wr    = h_wr && !h_rd;
    assign h_claim  = acc;

    cfgb_addr_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (latch_wr),
        .wdata (h_wdata),
        .q     (sel_q),
        .en    (sel_en),
        .sel   (sel)
    );

    cfgb_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (c_req && !c_ack),
        .hit   (tmo_hit)
    );

    cfgb_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .is_addr  (hit_sel),
        .is_wr    (is_wr),
        .en       (sel_en),
        .sel_q    (sel_q),
        .h_wdata  (h_wdata),
        .c_ack    (c_ack),
        .c_rdata  (c_rdata),
        .tmo_hit  (tmo_hit),
        .latch_wr (latch_wr),
        .h_ready  (h_ready),
        .h_rdata  (h_rdata),
        .c_req    (c_req),
        .c_we     (c_we),
        .c_wdata  (c_wdata)
    );

    assign c_bus = sel.bus;
    assign c_dev = sel.dev;
    assign c_fn  = sel.fn;
    assign c_dw  = sel.dw;

    assert_req_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_req |-> sel_en);

    assert_ack_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && c_ack) |=> (h_ready && !c_req));

    assert_timeout_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && tmo_hit) |=> (h_ready && !c_req));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (c_req && !c_ack && !tmo_hit) |=>
            (c_req && $stable({c_bus, c_dev, c_fn, c_dw, c_we, c_wdata})));

endmodule

// File: tb/cfg_port_bridge_test.sv
`timescale 1ns/1ps
module cfg_port_bridge_test;

    localparam int          TMO  = 16;
    localparam logic [15:0] PSEL = 16'h0CF8;
    localparam logic [15:0] PDAT = 16'h0CFC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_addr = '0;
    logic        h_rd = 1'b0, h_wr = 1'b0;
    logic [31:0] h_wdata = '0, h_rdata;
    logic        h_ready, h_claim, c_req, c_we, c_ack = 1'b0;
    logic [7:0]  c_bus;
    logic [4:0]  c_dev;
    logic [2:0]  c_fn;
    logic [5:0]  c_dw;
    logic [31:0] c_wdata, c_rdata = '0;

    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    cfg_port_bridge uut (
        .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_rd(h_rd), .h_wr(h_wr),
        .h_wdata(h_wdata), .h_rdata(h_rdata), .h_ready(h_ready), .h_claim(h_claim),
        .c_req(c_req), .c_bus(c_bus), .c_dev(c_dev), .c_fn(c_fn), .c_dw(c_dw),
        .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata), .c_ack(c_ack)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural config target ----------------
    logic [31:0] tgt_mem [int];
    int tgt_delay = 0;
    int tcnt = 0;

    function automatic int idx_of(input logic [7:0] b, input logic [4:0] d,
                                  input logic [2:0] f, input logic [5:0] w);
        return {10'd0, b, d, f, w};
    endfunction

    function automatic logic [31:0] tgt_val(input int i);
        if (tgt_mem.exists(i)) return tgt_mem[i];
        return 32'h5A00_0000 ^ (i * 32'h0001_0203);
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            c_ack <= 1'b0; tcnt = 0;
        end else if (c_req && !c_ack) begin
            if (tcnt == tgt_delay && c_dev < 5'd8) begin
                c_ack <= 1'b1;
                c_rdata <= tgt_val(idx_of(c_bus, c_dev, c_fn, c_dw));
                if (c_we) tgt_mem[idx_of(c_bus, c_dev, c_fn, c_dw)] = c_wdata;
            end
            tcnt++;
        end else begin
            c_ack <= 1'b0; tcnt = 0;
        end
    end

    // ---------------- cycle reference model ----------------
    int          m_ph = 0;     // 0 idle, 1 request, 2 respond
    int          m_wait = 0;
    logic [31:0] m_latch = '0, m_rdata = '0, m_wd = '0;
    logic        m_rd = 1'b0, m_we = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_latch = '0;
        end else begin
            logic strobe, ha, hd;
            strobe = h_rd || h_wr;
            ha = (h_addr == PSEL);
            hd = (h_addr == PDAT);
            check("R8 claim", {31'd0, h_claim}, {31'd0, strobe && (ha || hd)});
            check("R9 ready", {31'd0, h_ready}, {31'd0, m_ph == 2});
            check("R4 req", {31'd0, c_req}, {31'd0, m_ph == 1});
            if (m_ph == 1) begin
                check("R3 bus", {24'd0, c_bus}, {24'd0, m_latch[23:16]});
                check("R3 dev", {27'd0, c_dev}, {27'd0, m_latch[15:11]});
                check("R3 fn",  {29'd0, c_fn},  {29'd0, m_latch[10:8]});
                check("R3 dw",  {26'd0, c_dw},  {26'd0, m_latch[7:2]});
                check("R5 we", {31'd0, c_we}, {31'd0, m_we});
                if (m_we) check("R5 wdata", c_wdata, m_wd);
            end
            if (m_ph == 2 && m_rd) check("R4 rdata", h_rdata, m_rdata);
            case (m_ph)
                0: if (strobe && (ha || hd)) begin
                       m_rd = h_rd;
                       m_we = h_wr && !h_rd;
                       m_wd = h_wdata;
                       if (ha) begin
                           if (m_we) m_latch = h_wdata & 32'h80FF_FFFC;
                           else      m_rdata = m_latch;
                           m_ph = 2;
                       end else if (m_latch[31]) begin
                           m_ph = 1; m_wait = 0;
                       end else begin
                           m_rdata = 32'hFFFF_FFFF; m_ph = 2;
                       end
                   end
                1: if (c_ack) begin
                       if (!m_we) m_rdata = c_rdata;
                       m_ph = 2;
                   end else if (m_wait == TMO - 1) begin
                       m_rdata = 32'hFFFF_FFFF; m_ph = 2;
                   end else m_wait++;
                default: m_ph = 0;
            endcase
        end
    end

    // ---------------- host tasks ----------------
    task automatic host_op(input logic rd, input logic wr, input logic [15:0] a,
                           input logic [31:0] d, output logic [31:0] q);
        @(negedge clk);
        h_rd = rd; h_wr = wr; h_addr = a; h_wdata = d;
        do @(negedge clk); while (!h_ready);
        q = h_rdata;
        h_rd = 1'b0; h_wr = 1'b0;
    endtask

    task automatic sel_write(input logic [31:0] v);
        logic [31:0] q;
        host_op(1'b0, 1'b1, PSEL, v, q);
    endtask

    task automatic unclaimed(input logic rd, input logic [15:0] a);
        @(negedge clk);
        h_rd = rd; h_wr = !rd; h_addr = a; h_wdata = 32'h0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            check("R8 no ready", {31'd0, h_ready}, 32'd0);
            check("R8 no req", {31'd0, c_req}, 32'd0);
        end
        h_rd = 1'b0; h_wr = 1'b0;
    endtask

    function automatic logic [31:0] mksel(input logic e, input logic [7:0] b,
                                          input logic [4:0] d, input logic [2:0] f,
                                          input logic [5:0] w);
        return {e, 7'd0, b, d, f, w, 2'b00};
    endfunction

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0] q;
        repeat (3) @(negedge clk);
        check("R1 ready", {31'd0, h_ready}, 32'd0);
        check("R1 req", {31'd0, c_req}, 32'd0);
        rst_n = 1'b1;
        host_op(1'b1, 1'b0, PSEL, 0, q);
        check("R1 sel reset", q, 32'h0);

        // R2 selector storage and readback
        sel_write(32'h8000_000C);
        host_op(1'b1, 1'b0, PSEL, 0, q);
        check("R2 readback", q, 32'h8000_000C);
        sel_write(32'hFFFF_FFFF);
        host_op(1'b1, 1'b0, PSEL, 0, q);
        check("R2 masked", q, 32'h80FF_FFFC);

        // R3/R4 reads at several selectors and delays
        tgt_delay = 0;
        sel_write(mksel(1, 8'h00, 5'd0, 3'd0, 6'd3));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R4 read d0", q, tgt_val(idx_of(0, 0, 0, 3)));
        tgt_delay = 3;
        sel_write(mksel(1, 8'hA5, 5'd7, 3'd5, 6'd63));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R3 read mixed", q, tgt_val(idx_of(8'hA5, 7, 5, 63)));

        // R5 write then read back
        tgt_delay = 2;
        sel_write(mksel(1, 8'h01, 5'd1, 3'd2, 6'd16));
        host_op(1'b0, 1'b1, PDAT, 32'h1234_5678, q);
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R5 write readback", q, 32'h1234_5678);

        // R6 disabled window
        sel_write(mksel(0, 8'h01, 5'd1, 3'd2, 6'd16));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R6 disabled read", q, 32'hFFFF_FFFF);
        host_op(1'b0, 1'b1, PDAT, 32'hDEAD_BEEF, q);
        sel_write(mksel(1, 8'h01, 5'd1, 3'd2, 6'd16));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R6 write dropped", q, 32'h1234_5678);

        // R7 timeout boundary and absent device
        tgt_delay = TMO - 1;
        sel_write(mksel(1, 8'h02, 5'd3, 3'd0, 6'd0));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R7 late ack", q, tgt_val(idx_of(2, 3, 0, 0)));
        tgt_delay = TMO;
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R7 expired", q, 32'hFFFF_FFFF);
        tgt_delay = 0;
        sel_write(mksel(1, 8'h00, 5'd9, 3'd0, 6'd0));
        host_op(1'b1, 1'b0, PDAT, 0, q);
        check("R7 absent read", q, 32'hFFFF_FFFF);
        host_op(1'b0, 1'b1, PDAT, 32'h0BAD_F00D, q);
        check("R7 absent write done", {31'd0, c_req}, 32'd0);

        // R8 other ports
        unclaimed(1'b1, 16'h0CF9);
        unclaimed(1'b0, 16'h0CFA);
        unclaimed(1'b0, 16'h0080);
        host_op(1'b1, 1'b0, PSEL, 0, q);
        check("R8 sel kept", q, mksel(1, 8'h00, 5'd9, 3'd0, 6'd0));

        // R9 back-to-back accesses
        tgt_delay = 1;
        sel_write(mksel(1, 8'h03, 5'd2, 3'd1, 6'd5));
        for (int k = 0; k < 4; k++) begin
            host_op(1'b0, 1'b1, PDAT, 32'hC0DE_0000 + k, q);
            host_op(1'b1, 1'b0, PDAT, 0, q);
            check("R9 back-to-back", q, 32'hC0DE_0000 + k);
        end

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule